// File: doc/BRIEF.md
# DDR4 Registered-Module Power-Up Sequencer

This block is a hardware state machine that walks a DDR4 registered memory module through its power-up command list on a single-phase command port. Each command appears as a one-cycle strobe together with an address word, a bank address and a two-bit command code. A start pulse launches the list. The list first takes the DRAM out of reset and raises the clock enable. When registered mode is selected, it then resets and programs the module's register/clock driver through control-word writes. It ends with the seven DRAM mode register loads. After every command the sequencer holds off for a cycle count fixed by a parameter.

Configuration is read at start. Inputs give three drive-strength fields, a PLL bypass flag, the data rate in MT/s and the seven mode-register words. From the data rate the block derives a coarse speed code and a fine speed code and places them in two of the driver words. When registered mode is selected, bypass is clear and no speed step covers the rate, the block raises an error flag and does not start.

Top module: `rdimm_init_seq`

## Requirements
- R1: While `rst_n` is sampled low, and in the cycle after each such edge, `busy`, `done`, `cfg_err` and `cmd_valid` are 0, and `cmd_code`, `cmd_addr` and `cmd_ba` are 0.
- R2: If `start` is sampled high while the block is idle and the configuration is valid, `busy` is high from the next cycle. The first strobe comes one cycle after that. A `start` sampled while `busy` is high has no effect on the command stream or on `done`.
- R3: The first command is reset release (code 1, address 0, bank 0), followed by a wait of `RST_WAIT` cycles (default 50000). The second is clock-enable raise (code 2, address 0, bank 0), followed by a wait of `CKE_WAIT` cycles (default 10000). A command followed by a wait of W cycles has the next strobe exactly W+1 cycles after its own.
- R4: With `rdimm_en` high, seven mode-register-set commands (code 3) on bank address 7 come between clock-enable and the first DRAM load. Their addresses are, in order: 0x060, 0x0F4, 0x030 OR `drv_ca_cs`, 0x040 OR `drv_odt_cke`, 0x050 OR `drv_clk`, 0x0A0 OR coarse code, and 0x300 OR fine code. The first is followed by `RCD_RST_WAIT` cycles (default 50000) and each of the others by `RCD_WR_WAIT` cycles (default 100).
- R5: The coarse code is 7 when `pll_bypass` is high. Otherwise it is the index of the first entry of the list 1600, 1866, 2133, 2400, 2666, 2933, 3200 that is at least `data_rate`.
- R6: The fine code is floor((`data_rate` − 1240) / 20), taken as 0 for rates below 1240 and limited to 97.
- R7: The DRAM loads are mode-register-set commands (code 3) for MR3, MR6, MR5, MR4, MR2, MR1, MR0 in that order. The bank address equals the register number, and the address is slot n of `mr_words` (bits n·ADDR_W upward). Each load is followed by `MR_WAIT` cycles (default 0).
- R8: With `rdimm_en` low, no driver command is issued and no strobe carries bank address 7. MR3 comes directly after clock-enable.
- R9: A `start` sampled in idle with `rdimm_en` high, `pll_bypass` low and `data_rate` above 3200 sets `cfg_err` and leaves `busy` low. Any accepted start clears `cfg_err`.
- R10: `done` is a one-cycle pulse `MR_WAIT`+1 cycles after the MR0 strobe. `busy` falls in that same cycle.
- R11: All configuration inputs are captured when a start is accepted. Changes during a run do not alter that run's commands.
- R12: In every cycle without a strobe, `cmd_code`, `cmd_addr` and `cmd_ba` are 0. No strobe occurs while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| rdimm_en | input | 1 | Include the register/clock driver programming steps |
| pll_bypass | input | 1 | Driver PLL bypass; forces coarse code 7 |
| data_rate | input | 12 | Operating data rate in MT/s |
| drv_ca_cs | input | 4 | Command/address and chip-select drive field |
| drv_odt_cke | input | 4 | ODT and clock-enable drive field |
| drv_clk | input | 4 | Clock output drive field |
| mr_words | input | 98 | Seven DRAM mode-register words, slot n for MRn |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Last start refused for an uncovered data rate |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 2 | 0 none, 1 reset release, 2 clock-enable raise, 3 mode-register set |
| cmd_addr | output | 14 | Command address word |
| cmd_ba | output | 3 | Command bank address |

## Verification
Some properties are checked on every cycle by the assertions. The port is quiet when the block is idle, and `busy` never rises without a start. `done` always closes a busy period. A start with a rate above the top step is refused, and bank 7 never appears when registered mode is off. The exact order of the command words, the cycle spacing set by each wait, and the coarse and fine code values at their boundaries (1866, 3200, 1240, and rates large enough to clamp) can only be shown by the bench's scenarios. The same holds for a second start or changed configuration during a run, and for a reset in the middle of the sequence.

// File: rtl/rdimm_init_pkg.sv
// Shared definitions for the registered-module power-up sequencer.
// Assumes the fixed 16-entry step list: two power steps, seven driver
// control-word steps, seven DRAM mode-register loads.
package rdimm_init_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_RST_OFF = 2'd1,
        CMD_CKE_ON  = 2'd2,
        CMD_MRS     = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FIN
    } seq_state_e;

    localparam int STEP_W       = 4;
    localparam int IDX_CKE      = 1;
    localparam int IDX_MR_FIRST = 9;
    localparam int IDX_LAST     = 15;
    localparam int NUM_MR       = 7;
    localparam int NUM_RATES    = 7;
    localparam int DRV_BANK     = 7;
    localparam int TOP_RATE     = 3200;

    // Speed step list in MT/s, scanned from lowest to highest.
    function automatic int rate_step(input int i);
        case (i)
            0:       return 1600;
            1:       return 1866;
            2:       return 2133;
            3:       return 2400;
            4:       return 2666;
            5:       return 2933;
            default: return 3200;
        endcase
    endfunction

endpackage

// File: rtl/rdimm_speed_calc.sv
// Derives the coarse and fine speed codes from the data rate.
// Combinational; assumes RATE_W >= 12 so that every list step fits.
module rdimm_speed_calc
    import rdimm_init_pkg::*;
#(
    parameter int RATE_W = 12
) (
    input  logic [RATE_W-1:0] data_rate,
    input  logic              pll_bypass,
    output logic [2:0]        coarse,
    output logic [6:0]        fine,
    output logic              rate_ok
);

    localparam logic [RATE_W-1:0] FINE_BASE = RATE_W'(1240);
    localparam logic [RATE_W-1:0] FINE_STEP = RATE_W'(20);
    localparam logic [RATE_W-1:0] FINE_MAX  = RATE_W'(97);

    logic [RATE_W-1:0] step_rate [NUM_RATES];
    logic [RATE_W-1:0] quot;
    logic              found;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_steps
        assign step_rate[g] = RATE_W'(rate_step(g));
    end

    // Coarse code: first list step not below the rate, bypass overrides.
    always_comb begin
        coarse = 3'd7;
        found  = 1'b0;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (!found && data_rate <= step_rate[i]) begin
                coarse = 3'(i);
                found  = 1'b1;
            end
        end
        if (pll_bypass) begin
            coarse = 3'd7;
        end
        rate_ok = found || pll_bypass;
    end

    // Fine code: 20 MT/s granules above 1240, clamped to 0..97.
    always_comb begin
        if (data_rate < FINE_BASE) begin
            quot = '0;
        end else begin
            quot = (data_rate - FINE_BASE) / FINE_STEP;
        end
        fine = (quot > FINE_MAX) ? 7'd97 : quot[6:0];
    end

endmodule

// File: rtl/rdimm_step_table.sv
// Maps a step index and the captured configuration to one command:
// code, address word, bank address and the wait that follows it.
// Assumes ADDR_W >= 12 so driver words are not truncated.
module rdimm_step_table
    import rdimm_init_pkg::*;
#(
    parameter int ADDR_W       = 14,
    parameter int CNT_W        = 16,
    parameter int RST_WAIT     = 50000,
    parameter int CKE_WAIT     = 10000,
    parameter int RCD_RST_WAIT = 50000,
    parameter int RCD_WR_WAIT  = 100,
    parameter int MR_WAIT      = 0
) (
    input  logic [STEP_W-1:0]        step_idx,
    input  logic [3:0]               ca_cs,
    input  logic [3:0]               odt_cke,
    input  logic [3:0]               clk_drv,
    input  logic [2:0]               coarse,
    input  logic [6:0]               fine,
    input  logic [NUM_MR*ADDR_W-1:0] mr_words,
    output cmd_e                     code,
    output logic [ADDR_W-1:0]        addr,
    output logic [2:0]               ba,
    output logic [CNT_W-1:0]         wait_cyc
);

    logic [ADDR_W-1:0] mr_arr [NUM_MR];
    logic [2:0]        mr_sel;
    logic [11:0]       word;
    logic              use_word;

    for (genvar g = 0; g < NUM_MR; g++) begin : g_mr
        assign mr_arr[g] = mr_words[g*ADDR_W +: ADDR_W];
    end

    // Mode-register number for each load step, in issue order.
    always_comb begin
        case (step_idx)
            4'd9:    mr_sel = 3'd3;
            4'd10:   mr_sel = 3'd6;
            4'd11:   mr_sel = 3'd5;
            4'd12:   mr_sel = 3'd4;
            4'd13:   mr_sel = 3'd2;
            4'd14:   mr_sel = 3'd1;
            default: mr_sel = 3'd0;
        endcase
    end

    // Command contents for the selected step.
    always_comb begin
        code     = CMD_MRS;
        ba       = 3'(DRV_BANK);
        word     = 12'h000;
        use_word = 1'b1;
        wait_cyc = CNT_W'(RCD_WR_WAIT);
        case (step_idx)
            4'd0: begin
                code     = CMD_RST_OFF;
                ba       = 3'd0;
                wait_cyc = CNT_W'(RST_WAIT);
            end
            4'd1: begin
                code     = CMD_CKE_ON;
                ba       = 3'd0;
                wait_cyc = CNT_W'(CKE_WAIT);
            end
            4'd2: begin
                word     = 12'h060;
                wait_cyc = CNT_W'(RCD_RST_WAIT);
            end
            4'd3: word = 12'h0F4;
            4'd4: word = {8'h03, ca_cs};
            4'd5: word = {8'h04, odt_cke};
            4'd6: word = {8'h05, clk_drv};
            4'd7: word = {8'h0A, 1'b0, coarse};
            4'd8: word = {4'h3, 1'b0, fine};
            default: begin
                use_word = 1'b0;
                ba       = mr_sel;
                wait_cyc = CNT_W'(MR_WAIT);
            end
        endcase
        addr = use_word ? ADDR_W'(word) : mr_arr[mr_sel];
    end

endmodule

// File: rtl/rdimm_wait_timer.sv
// Down-counter for the hold-off after each command. A load sets the
// count; 'last' marks the final cycle of the hold-off.
module rdimm_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    // Count down to zero after each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(1));

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> (cnt == '0)); // R3

endmodule

// File: rtl/rdimm_init_seq.sv
// Power-up sequencer for a DDR4 registered module. Accepts a start
// pulse in idle, captures the configuration, walks the step list and
// emits one registered strobe per command with the programmed hold-off.
// Assumes a single-phase command port that consumes every strobe.
module rdimm_init_seq
    import rdimm_init_pkg::*;
#(
    parameter int ADDR_W       = 14,
    parameter int RATE_W       = 12,
    parameter int RST_WAIT     = 50000,
    parameter int CKE_WAIT     = 10000,
    parameter int RCD_RST_WAIT = 50000,
    parameter int RCD_WR_WAIT  = 100,
    parameter int MR_WAIT      = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     rdimm_en,
    input  logic                     pll_bypass,
    input  logic [RATE_W-1:0]        data_rate,
    input  logic [3:0]               drv_ca_cs,
    input  logic [3:0]               drv_odt_cke,
    input  logic [3:0]               drv_clk,
    input  logic [NUM_MR*ADDR_W-1:0] mr_words,
    output logic                     busy,
    output logic                     done,
    output logic                     cfg_err,
    output logic                     cmd_valid,
    output logic [1:0]               cmd_code,
    output logic [ADDR_W-1:0]        cmd_addr,
    output logic [2:0]               cmd_ba
);

    localparam int MAX_A    = (RST_WAIT > CKE_WAIT) ? RST_WAIT : CKE_WAIT;
    localparam int MAX_B    = (RCD_RST_WAIT > RCD_WR_WAIT) ? RCD_RST_WAIT : RCD_WR_WAIT;
    localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_WAIT = (MAX_C > MR_WAIT) ? MAX_C : MR_WAIT;
    localparam int CNT_W    = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);

    seq_state_e               state;
    logic [STEP_W-1:0]        idx;
    logic [STEP_W-1:0]        idx_next;
    logic                     rdimm_q;
    logic [3:0]               ca_q, odt_q, clk_q;
    logic [2:0]               coarse_q;
    logic [6:0]               fine_q;
    logic [NUM_MR*ADDR_W-1:0] mr_q;
    logic [2:0]               coarse_w;
    logic [6:0]               fine_w;
    logic                     rate_ok;
    logic                     cfg_ok;
    cmd_e                     tbl_code;
    logic [ADDR_W-1:0]        tbl_addr;
    logic [2:0]               tbl_ba;
    logic [CNT_W-1:0]         tbl_wait;
    logic                     tmr_load;
    logic                     tmr_last;
    logic                     step_end;
    cmd_e                     code_q;

    rdimm_speed_calc #(.RATE_W(RATE_W)) u_speed (
        .data_rate  (data_rate),
        .pll_bypass (pll_bypass),
        .coarse     (coarse_w),
        .fine       (fine_w),
        .rate_ok    (rate_ok)
    );

    rdimm_step_table #(
        .ADDR_W       (ADDR_W),
        .CNT_W        (CNT_W),
        .RST_WAIT     (RST_WAIT),
        .CKE_WAIT     (CKE_WAIT),
        .RCD_RST_WAIT (RCD_RST_WAIT),
        .RCD_WR_WAIT  (RCD_WR_WAIT),
        .MR_WAIT      (MR_WAIT)
    ) u_table (
        .step_idx (idx),
        .ca_cs    (ca_q),
        .odt_cke  (odt_q),
        .clk_drv  (clk_q),
        .coarse   (coarse_q),
        .fine     (fine_q),
        .mr_words (mr_q),
        .code     (tbl_code),
        .addr     (tbl_addr),
        .ba       (tbl_ba),
        .wait_cyc (tbl_wait)
    );

    rdimm_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tbl_wait),
        .last     (tmr_last)
    );

    // A start is refused only when the driver steps need a speed code.
    assign cfg_ok   = !rdimm_en || rate_ok;
    // Skip the driver block when registered mode was not captured.
    assign idx_next = (idx == STEP_W'(IDX_CKE) && !rdimm_q) ? STEP_W'(IDX_MR_FIRST)
                                                             : idx + 1'b1;
    assign tmr_load = (state == ST_ISSUE) && (tbl_wait != '0);
    assign step_end = ((state == ST_ISSUE) && (tbl_wait == '0)) ||
                      ((state == ST_WAIT) && tmr_last);

    // Sequencer state, configuration capture and registered command port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            rdimm_q  <= 1'b0;
            ca_q     <= '0;
            odt_q    <= '0;
            clk_q    <= '0;
            coarse_q <= '0;
            fine_q   <= '0;
            mr_q     <= '0;
            cfg_err  <= 1'b0;
            done     <= 1'b0;
            cmd_valid <= 1'b0;
            code_q   <= CMD_NONE;
            cmd_addr <= '0;
            cmd_ba   <= '0;
        end else begin
            done      <= 1'b0;
            cmd_valid <= 1'b0;
            code_q    <= CMD_NONE;
            cmd_addr  <= '0;
            cmd_ba    <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (cfg_ok) begin
                            rdimm_q  <= rdimm_en;
                            ca_q     <= drv_ca_cs;
                            odt_q    <= drv_odt_cke;
                            clk_q    <= drv_clk;
                            coarse_q <= coarse_w;
                            fine_q   <= fine_w;
                            mr_q     <= mr_words;
                            cfg_err  <= 1'b0;
                            idx      <= '0;
                            state    <= ST_ISSUE;
                        end else begin
                            cfg_err  <= 1'b1;
                        end
                    end
                end
                ST_ISSUE, ST_WAIT: begin
                    if (state == ST_ISSUE) begin
                        cmd_valid <= 1'b1;
                        code_q    <= tbl_code;
                        cmd_addr  <= tbl_addr;
                        cmd_ba    <= tbl_ba;
                        if (tbl_wait != '0) begin
                            state <= ST_WAIT;
                        end
                    end
                    if (step_end) begin
                        if (idx == STEP_W'(IDX_LAST)) begin
                            state <= ST_FIN;
                        end else begin
                            idx   <= idx_next;
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_FIN: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign cmd_code = code_q;

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R2
    AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && rdimm_en && !pll_bypass && data_rate > RATE_W'(TOP_RATE))
        |=> (!busy && cfg_err)); // R9
    AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy)); // R10
    AST_NO_DRV_BANK_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !rdimm_q) |-> (cmd_ba != 3'(DRV_BANK))); // R8
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_valid && cmd_code == 2'd0)); // R12
    AST_FINE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (fine_q <= 7'd97)); // R6

endmodule

// File: tb/test_rdimm_init_seq.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural schedule of expected strobes is
// built at each accepted start and compared with the port every cycle.
module test_rdimm_init_seq;

    localparam int AW     = 14;
    localparam int P_RST  = 30;
    localparam int P_CKE  = 12;
    localparam int P_RCDR = 20;
    localparam int P_RCDW = 3;
    localparam int P_MR   = 0;

    typedef struct {
        int    at;
        int    code;
        int    addr;
        int    ba;
        string req;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            rdimm_en = 1'b0;
    logic            pll_bypass = 1'b0;
    logic [11:0]     data_rate = 12'd2400;
    logic [3:0]      d_ca = 4'd5, d_odt = 4'd5, d_clk = 4'd5;
    logic [7*AW-1:0] mr_words;
    int              mr_val [7];

    logic            busy, done, cfg_err, cmd_valid;
    logic [1:0]      cmd_code;
    logic [AW-1:0]   cmd_addr;
    logic [2:0]      cmd_ba;

    exp_t  exp_q [$];
    int    edge_n = 0;
    int    done_at = -1;
    int    busy_from = 0;
    int    err_exp = 0;
    int    err_next = 0;
    int    err_at = -1;
    int    n_chk = 0;
    int    n_fail = 0;
    string note = "";
    bit    finished = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 7; i++) mr_words[i*AW +: AW] = AW'(mr_val[i]);
    end

    rdimm_init_seq #(
        .ADDR_W(AW), .RATE_W(12), .RST_WAIT(P_RST), .CKE_WAIT(P_CKE),
        .RCD_RST_WAIT(P_RCDR), .RCD_WR_WAIT(P_RCDW), .MR_WAIT(P_MR)
    ) i_rdimm_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rdimm_en(rdimm_en),
        .pll_bypass(pll_bypass), .data_rate(data_rate), .drv_ca_cs(d_ca),
        .drv_odt_cke(d_odt), .drv_clk(d_clk), .mr_words(mr_words),
        .busy(busy), .done(done), .cfg_err(cfg_err), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_ba(cmd_ba)
    );

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s edge %0d: actual 0x%0h expected 0x%0h", req, what, edge_n, act, expv);
        end
    endtask

    function automatic int coarse_of(input int rate, input bit byp);
        int steps [7] = '{1600, 1866, 2133, 2400, 2666, 2933, 3200};
        if (byp) return 7;
        for (int i = 0; i < 7; i++) if (rate <= steps[i]) return i;
        return -1;
    endfunction

    function automatic int fine_of(input int rate);
        int f;
        f = (rate < 1240) ? 0 : (rate - 1240) / 20;
        return (f > 97) ? 97 : f;
    endfunction

    function automatic string tag(input string base);
        return (note == "") ? base : {base, "/", note};
    endfunction

    // Model time base, reset clearing and delayed error-flag update.
    always @(posedge clk) begin
        edge_n++;
        if (!rst_n) begin
            exp_q.delete();
            done_at   = -1;
            busy_from = 0;
            err_exp   = 0;
            err_at    = -1;
        end else if (edge_n == err_at) begin
            err_exp = err_next;
        end
    end

    // Compare the port with the model once per cycle, between edges.
    always @(negedge clk) begin
        if (edge_n >= 1 && !finished) begin
            string rq;
            rq = (!rst_n) ? "R1" : "R12";
            if (exp_q.size() > 0 && exp_q[0].at == edge_n) begin
                chk(exp_q[0].req, "cmd_valid", int'(cmd_valid), 1);
                chk(exp_q[0].req, "cmd_code",  int'(cmd_code), exp_q[0].code);
                chk(exp_q[0].req, "cmd_addr",  int'(cmd_addr), exp_q[0].addr);
                chk(exp_q[0].req, "cmd_ba",    int'(cmd_ba),   exp_q[0].ba);
                void'(exp_q.pop_front());
            end else begin
                chk(rq, "cmd_valid", int'(cmd_valid), 0);
                chk(rq, "cmd_code/addr/ba", int'(cmd_code) | int'(cmd_addr) | int'(cmd_ba), 0);
            end
            chk((!rst_n) ? "R1" : "R2",  "busy",    int'(busy), (edge_n >= busy_from && edge_n < done_at) ? 1 : 0);
            chk((!rst_n) ? "R1" : "R10", "done",    int'(done), (edge_n == done_at) ? 1 : 0);
            chk((!rst_n) ? "R1" : "R9",  "cfg_err", int'(cfg_err), err_exp);
        end
    end

    task automatic push(input int at, input int code, input int addr, input int ba, input string req);
        exp_t e;
        e.at = at; e.code = code; e.addr = addr; e.ba = ba; e.req = req;
        exp_q.push_back(e);
    endtask

    // Drive a start pulse and extend the model with its schedule.
    task automatic pulse_start();
        int k, t, crs;
        int order [7] = '{3, 6, 5, 4, 2, 1, 0};
        @(negedge clk); #1;
        start = 1'b1;
        k = edge_n + 1;
        if (k > done_at) begin
            crs = coarse_of(int'(data_rate), pll_bypass);
            err_at = k;
            if (rdimm_en && crs < 0) begin
                err_next = 1;
            end else begin
                err_next = 0;
                busy_from = k;
                t = k + 1;
                push(t, 1, 0, 0, tag("R2/R3")); t += P_RST + 1;
                push(t, 2, 0, 0, tag("R3"));    t += P_CKE + 1;
                if (rdimm_en) begin
                    push(t, 3, 'h060, 7, tag("R4")); t += P_RCDR + 1;
                    push(t, 3, 'h0F4, 7, tag("R4")); t += P_RCDW + 1;
                    push(t, 3, 'h030 | int'(d_ca),  7, tag("R4")); t += P_RCDW + 1;
                    push(t, 3, 'h040 | int'(d_odt), 7, tag("R4")); t += P_RCDW + 1;
                    push(t, 3, 'h050 | int'(d_clk), 7, tag("R4")); t += P_RCDW + 1;
                    push(t, 3, 'h0A0 | crs,         7, tag("R5")); t += P_RCDW + 1;
                    push(t, 3, 'h300 | fine_of(int'(data_rate)), 7, tag("R6")); t += P_RCDW + 1;
                end
                for (int i = 0; i < 7; i++) begin
                    push(t, 3, mr_val[order[i]], order[i],
                         (i == 0 && !rdimm_en) ? tag("R8") : tag("R7"));
                    t += P_MR + 1;
                end
                done_at = t;
            end
        end
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_end();
        while (edge_n <= done_at + 1) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input bit rd, input bit byp, input int rate, input int base);
        @(negedge clk); #1;
        rdimm_en = rd; pll_bypass = byp; data_rate = 12'(rate);
        for (int i = 0; i < 7; i++) mr_val[i] = base + 16 * i + i;
    endtask

    initial begin
        for (int i = 0; i < 7; i++) mr_val[i] = i;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4 R5 R6: registered mode, 2400 MT/s -> coarse 3, fine 58
        set_cfg(1'b1, 1'b0, 2400, 'h0100);
        pulse_start(); wait_end();
        // R8: registered mode off, top-of-range rate accepted
        set_cfg(1'b0, 1'b0, 4000, 'h0200);
        pulse_start(); wait_end();
        // R5 R6: bypass gives coarse 7, fine clamps at 97
        set_cfg(1'b1, 1'b1, 4000, 'h0300);
        d_ca = 4'hA; d_odt = 4'h3; d_clk = 4'hF;
        pulse_start(); wait_end();
        // R11 R2: low rate, then a second start and new settings mid-run
        set_cfg(1'b1, 1'b0, 1000, 'h0400);
        note = "R11";
        pulse_start();
        repeat (15) @(negedge clk);
        pulse_start();
        #1 d_ca = 4'h1; d_odt = 4'h2; d_clk = 4'h4; data_rate = 12'd2000;
        for (int i = 0; i < 7; i++) mr_val[i] = 'h3FFF - i;
        wait_end();
        note = "";
        // R9: rate above the top step is refused, then a good start clears it
        set_cfg(1'b1, 1'b0, 3201, 'h0500);
        pulse_start(); repeat (5) @(negedge clk);
        set_cfg(1'b1, 1'b0, 1601, 'h0600);
        pulse_start(); wait_end();
        // R5 R6 boundaries: 1866 -> coarse 1, 3200 -> coarse 6 and fine 97
        set_cfg(1'b1, 1'b0, 1866, 'h0700);
        pulse_start(); wait_end();
        set_cfg(1'b1, 1'b0, 3200, 'h0800);
        pulse_start(); wait_end();
        // R1: reset in the middle of a run silences the port
        set_cfg(1'b1, 1'b0, 2666, 'h0900);
        pulse_start();
        repeat (40) @(negedge clk);
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (10) @(negedge clk);
        set_cfg(1'b0, 1'b0, 2133, 'h0A00);
        pulse_start(); wait_end();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #750000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule